// File: doc/BRIEF.md
# Downstream Targeted Reset Controller

This block lets software force a reset onto one downstream serial link port and then watch that port come back. Each port has a control register with a reset-request bit and a status register with a link-active bit. Software sets the request bit to drive the port's reset output. It clears the bit to release the reset. It then polls the status register until link-active returns, which happens only once the link-training logic has reported a fresh link-up.

Each port runs its own small state machine. The states are:

- `ST_TRAIN`: waiting for link-up.
- `ST_UP`: link active.
- `ST_HOLD`: reset asserted.
- `ST_RELEASE`: reset just released, waiting for the link-up input to be seen low.

The transitions are:

- HOLD entry: taken from any state when the request bit is set. It has priority over every other transition.
- HOLD→RELEASE: the request bit is clear.
- RELEASE→TRAIN: link-up is low.
- TRAIN→UP: link-up is high.
- UP→TRAIN: link-up is low.

Every state leaves reset in `ST_TRAIN`.

The register interface has three parts. A port select and a byte offset address one port's registers. A single-cycle write strobe writes the addressed register. A read strobe returns the addressed data one cycle later, marked by a valid pulse.

Top module: `drst_ctrl`

## Requirements
- R1: After reset, every port's reset output is low, every control register reads 0x00, and status reads 0x00 until that port's link-up input has been sampled high.
- R2: Writing a byte with bit 6 set to the control register (offset 0x3E) of a port sets that register's bit 6. The port's reset output is high from the second rising edge after the write and stays high for as long as the bit stays set. The control register then reads back 0x40.
- R3: While a port's reset output is high, its status register (offset 0x47) reads link-active (bit 1) as 0, even when its link-up input is high.
- R4: Writing 0x00 to the control register clears bit 6. The reset output goes low from the second rising edge after the write.
- R5: After the reset is released, a link-up level that has stayed high since the release does not set link-active. Link-up must first be sampled low.
- R6: Link-active becomes 1 only after link-up is sampled high in `ST_TRAIN`. A status read then returns 0x02.
- R7: Writes to the status register are ignored. They change neither the control bit, nor the reset output, nor the link-active value.
- R8: A targeted reset on one port leaves every other port's reset output, control value and status value unchanged.
- R9: A read strobe produces a valid pulse and its data on the next cycle. An unmapped offset reads 0x00.
- R10: If link-up drops while a port is in `ST_UP`, link-active clears on the next cycle and the port returns to `ST_TRAIN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_port | input | PSEL_W | Port select |
| cfg_addr | input | ADDR_W | Register byte offset |
| cfg_wdata | input | DATA_W | Write data |
| cfg_rdata | output | DATA_W | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read data valid, one cycle after cfg_rd |
| link_up_i | input | NUM_PORTS | Per-port link-up from the link-training logic |
| port_rst_o | output | NUM_PORTS | Per-port reset toward the link layer |

## Verification
The hardest situation to reach is the stale link-up case of R5. This is a reset so short that the link-training stub never drops link-up, so the input is still high when the reset is released. The bench writes the request bit and clears it on back-to-back cycles, so the reset output stays high for one cycle. The stub needs several cycles of reset before it drops the link. The bench then confirms at the ports that link-up is still high while status reads link-active as 0. It then forces the link down to show that the port recovers.

// File: rtl/drst_pkg.sv
package drst_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    // Register offsets and bit positions that software decodes
    localparam logic [ADDR_W-1:0] CTRL_OFS = 8'h3E;
    localparam logic [ADDR_W-1:0] STAT_OFS = 8'h47;
    localparam int RST_BIT  = 6;
    localparam int ACT_BIT  = 1;

    typedef enum logic [1:0] {
        ST_TRAIN   = 2'd0,
        ST_UP      = 2'd1,
        ST_HOLD    = 2'd2,
        ST_RELEASE = 2'd3
    } port_state_t;
endpackage

// File: rtl/drst_port_fsm.sv
module drst_port_fsm
    import drst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rst_req,
    input  logic link_up,
    output logic port_rst,
    output logic link_active
);
    port_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_TRAIN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (rst_req) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD:    state_d = ST_RELEASE;
                ST_RELEASE: if (!link_up) state_d = ST_TRAIN;
                ST_TRAIN:   if (link_up)  state_d = ST_UP;
                ST_UP:      if (!link_up) state_d = ST_TRAIN;
                default:    state_d = ST_TRAIN;
            endcase
        end
    end

    always_comb begin
        port_rst    = (state_q == ST_HOLD);
        link_active = (state_q == ST_UP);
    end

    assert_rst_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> port_rst);
    assert_inactive_in_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        port_rst |-> !link_active);
    assert_rst_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req |=> !port_rst);
    assert_no_stale_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(port_rst) |=> !link_active);
    assert_up_needs_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_active) |-> $past(link_up));
    assert_drop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (link_active && !link_up) |=> !link_active);
endmodule

// File: rtl/drst_regs.sv
module drst_regs
    import drst_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    localparam int PSEL_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic                 cfg_rd,
    input  logic [PSEL_W-1:0]    cfg_port,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    input  logic [NUM_PORTS-1:0] link_active,
    output logic [NUM_PORTS-1:0] rst_req,
    output logic [DATA_W-1:0]    cfg_rdata,
    output logic                 cfg_rvalid
);
    logic [DATA_W-1:0] rd_mux;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= '0;
        end else if (cfg_wr && cfg_addr == CTRL_OFS) begin
            for (int i = 0; i < NUM_PORTS; i++)
                if (cfg_port == i[PSEL_W-1:0]) rst_req[i] <= cfg_wdata[RST_BIT];
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (cfg_port == i[PSEL_W-1:0]) begin
                if (cfg_addr == CTRL_OFS) rd_mux[RST_BIT] = rst_req[i];
                if (cfg_addr == STAT_OFS) rd_mux[ACT_BIT] = link_active[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
        end else begin
            cfg_rvalid <= cfg_rd;
            cfg_rdata  <= cfg_rd ? rd_mux : '0;
        end
    end

    assert_status_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == STAT_OFS) |=> $stable(rst_req));
    assert_read_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd |=> cfg_rvalid);
endmodule

// File: rtl/drst_ctrl.sv
module drst_ctrl
    import drst_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    localparam int PSEL_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic                 cfg_rd,
    input  logic [PSEL_W-1:0]    cfg_port,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    output logic                 cfg_rvalid,
    input  logic [NUM_PORTS-1:0] link_up_i,
    output logic [NUM_PORTS-1:0] port_rst_o
);
    logic [NUM_PORTS-1:0] rst_req;
    logic [NUM_PORTS-1:0] link_active;

    drst_regs #(.NUM_PORTS(NUM_PORTS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_rd     (cfg_rd),
        .cfg_port   (cfg_port),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .link_active(link_active),
        .rst_req    (rst_req),
        .cfg_rdata  (cfg_rdata),
        .cfg_rvalid (cfg_rvalid)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        drst_port_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .rst_req    (rst_req[p]),
            .link_up    (link_up_i[p]),
            .port_rst   (port_rst_o[p]),
            .link_active(link_active[p])
        );
    end

    assert_ports_quiet_after_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (port_rst_o == '0));
endmodule

// File: tb/drst_ctrl_bench.sv
module drst_ctrl_bench;
    localparam int NP = 2;
    localparam int DROP_LAT  = 4;
    localparam int TRAIN_LAT = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [0:0] cfg_port = '0;
    logic [7:0] cfg_addr = '0, cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic cfg_rvalid;
    logic [NP-1:0] link_up = '0;
    logic [NP-1:0] force_down = '0;
    logic [NP-1:0] port_rst;

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    drst_ctrl #(.NUM_PORTS(NP)) u_drst_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_port(cfg_port), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
        .link_up_i(link_up), .port_rst_o(port_rst)
    );

    // Link-training stub: drops link after DROP_LAT cycles of reset, trains after release
    int drop_cnt[NP];
    int train_cnt[NP];
    always @(posedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (!rst_n) begin
                link_up[p] <= 1'b0; drop_cnt[p] <= 0; train_cnt[p] <= 0;
            end else if (force_down[p]) begin
                link_up[p] <= 1'b0; train_cnt[p] <= 0;
            end else if (port_rst[p]) begin
                drop_cnt[p] <= drop_cnt[p] + 1;
                if (drop_cnt[p] + 1 >= DROP_LAT) begin
                    link_up[p] <= 1'b0; train_cnt[p] <= 0;
                end
            end else begin
                drop_cnt[p] <= 0;
                if (!link_up[p]) begin
                    train_cnt[p] <= train_cnt[p] + 1;
                    if (train_cnt[p] + 1 >= TRAIN_LAT) link_up[p] <= 1'b1;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int port, input logic [7:0] addr, input logic [7:0] data);
        cfg_wr = 1'b1; cfg_port = port[0:0]; cfg_addr = addr; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input int port, input logic [7:0] addr, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        cfg_rd = 1'b1; cfg_port = port[0:0]; cfg_addr = addr;
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: pop expected items as read data emerges
    always @(negedge clk) begin
        if (rst_n && cfg_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9 unexpected read data got %h exp none", cfg_rdata);
            end else begin
                check(tag_q.pop_front(), cfg_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        int wd;
        wd = 0;
        while (wd < 100000) begin @(posedge clk); wd++; end
        checks++; errors++;
        $display("FAIL watchdog got timeout exp completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 port_rst after reset", {6'd0, port_rst}, 8'h00);
        rd(0, 8'h3E, 8'h00, "R1 ctrl p0 after reset");
        rd(0, 8'h47, 8'h00, "R1 status p0 before link-up");
        idle(TRAIN_LAT + 4);
        rd(0, 8'h47, 8'h02, "R6 status p0 after training");
        rd(1, 8'h47, 8'h02, "R6 status p1 after training");
        rd(0, 8'h10, 8'h00, "R9 unmapped offset");

        wr(0, 8'h47, 8'hFF);
        idle(2);
        check("R7 port_rst after status write", {6'd0, port_rst}, 8'h00);
        rd(0, 8'h3E, 8'h00, "R7 ctrl after status write");
        rd(0, 8'h47, 8'h02, "R7 status after status write");

        wr(0, 8'h3E, 8'h40);
        @(negedge clk);
        check("R2 port_rst p0 asserted", {7'd0, port_rst[0]}, 8'h01);
        check("R3 link_up still high in reset", {7'd0, link_up[0]}, 8'h01);
        rd(0, 8'h47, 8'h00, "R3 status low while link_up high");
        rd(0, 8'h3E, 8'h40, "R2 ctrl readback");
        idle(20);
        check("R2 port_rst p0 held", {7'd0, port_rst[0]}, 8'h01);
        check("R8 port_rst p1 unaffected", {7'd0, port_rst[1]}, 8'h00);
        rd(1, 8'h47, 8'h02, "R8 status p1 unaffected");
        rd(1, 8'h3E, 8'h00, "R8 ctrl p1 unaffected");
        rd(0, 8'h47, 8'h00, "R3 status p0 during long reset");

        wr(0, 8'h3E, 8'h00);
        @(negedge clk);
        check("R4 port_rst p0 released", {7'd0, port_rst[0]}, 8'h00);
        rd(0, 8'h47, 8'h00, "R6 status p0 still training");
        idle(TRAIN_LAT + 6);
        rd(0, 8'h47, 8'h02, "R6 status p0 retrained");

        // Short pulse: link-up never drops, stale level must be ignored
        wr(1, 8'h3E, 8'h40);
        wr(1, 8'h3E, 8'h00);
        idle(20);
        check("R5 stale link_up p1 high", {7'd0, link_up[1]}, 8'h01);
        check("R5 port_rst p1 released", {7'd0, port_rst[1]}, 8'h00);
        rd(1, 8'h47, 8'h00, "R5 status p1 ignores stale link-up");
        force_down[1] = 1'b1;
        idle(2);
        force_down[1] = 1'b0;
        idle(TRAIN_LAT + 6);
        rd(1, 8'h47, 8'h02, "R5 status p1 after fresh training");

        force_down[0] = 1'b1;
        idle(3);
        rd(0, 8'h47, 8'h00, "R10 status p0 after link drop");
        force_down[0] = 1'b0;
        idle(TRAIN_LAT + 6);
        rd(0, 8'h47, 8'h02, "R10 status p0 back up");

        idle(3);
        check("R9 all reads answered", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule